// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one programmable logic element. Four single-bit data inputs (x, y, w, z), a clock and a set/reset strobe feed two 3-input lookup tables, a third-input selector for those tables, a selector in front of a storage flop, the flop itself, and two output selectors. The function is fixed by 8-bit configuration words loaded through a small write port: a 4-bit word selector, a data byte and a write strobe.

The lookup tables hold their truth tables in complemented form. Every selector falls back to a default path when none of its control bits is set. The flop can be bypassed, either toward the cell's centre output or toward its internal feedback line. The feedback line can in turn drive the third table input, which lets the flop take part in the cell's own logic function.

Top module: `cfg_logic_cell`

## Requirements
- R1: A write (cfg_we high at a rising clk edge) stores cfg_data into the word named by cfg_sel, and the new value acts from that edge on. The words are: selector 1 is the control word, selector 2 holds the set/reset polarity in bit 0, selector 6 is the X table and selector 7 is the Y table. A write to any other selector changes nothing.
- R2: While rst_n is low, every configuration bit and the flop are cleared. With no writes after reset, out_xo and out_yo read 1.
- R3: Each table output is the complement of table bit number {third, in_y, in_x}, where in_x is the least significant bit. The X table is word 6 and the Y table is word 7.
- R4: The third table input is in_w by default. It is in_w AND in_z when control bit 5 is set. It is the feedback line when bit 4 is set and bit 5 is clear, so bit 5 has priority.
- R5: When sr is low, the flop loads at each rising edge. By default it loads the X table output. It loads in_z when control bit 7 is set. It loads the Y table output when bit 6 is set and bit 7 is clear, so bit 7 has priority.
- R6: When sr is high at a rising edge, the flop goes to 1 if the polarity bit is 0 and to 0 if the polarity bit is 1. This overrides the normal load.
- R7: The centre output is in_z when control bit 3 is set and the flop value otherwise. The feedback line is in_z when control bit 2 is set and the flop value otherwise.
- R8: out_xo is the centre output when control bit 1 is set and the X table output otherwise. out_yo is the centre output when control bit 0 is set and the Y table output otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears configuration and flop |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration word selector |
| cfg_data | input | 8 | Configuration word data |
| in_x | input | 1 | Cell input x (table index bit 0) |
| in_y | input | 1 | Cell input y (table index bit 1) |
| in_w | input | 1 | Cell input w |
| in_z | input | 1 | Cell input z |
| sr | input | 1 | Set/reset strobe for the flop |
| out_xo | output | 1 | X output |
| out_yo | output | 1 | Y output |

## Verification
All sixteen combinations of x, y, w and z are swept under each control setting. Each sweep uses asymmetric table contents, so that a swapped index bit, a missing inversion or a wrong table shows up as a mismatch. The third-input selector is tried in its default, AND, feedback-from-flop and feedback-from-z settings, and with both of its bits set, which separates the priority order. The flop is observed through the centre output under each source choice, including both select bits set, and under both polarity values with sr interleaved. Writes to unused selectors are followed by a full sweep, which shows that no word was disturbed.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
    localparam int SEL_W  = 4;
    localparam int CFG_W  = 8;
    localparam int LUT_K  = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL = 4'h1;
    localparam logic [SEL_W-1:0] SEL_MODE = 4'h2;
    localparam logic [SEL_W-1:0] SEL_XTAB = 4'h6;
    localparam logic [SEL_W-1:0] SEL_YTAB = 4'h7;

    // control word, bit 7 first
    typedef struct packed {
        logic reg_from_z;
        logic reg_from_yl;
        logic wsel_and;
        logic wsel_fb;
        logic c_bypass;
        logic fb_bypass;
        logic c_to_xo;
        logic c_to_yo;
    } ctrl_t;
endpackage

// File: rtl/lcell_cfg_bank.sv
module lcell_cfg_bank
    import lcell_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int DW = CFG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  logic [DW-1:0] data,
    output ctrl_t         ctrl,
    output logic          pol,
    output logic [DW-1:0] xtab,
    output logic [DW-1:0] ytab
);
    logic [DW-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pol    <= 1'b0;
            xtab   <= '0;
            ytab   <= '0;
        end else if (we) begin
            unique case (sel)
                SW'(SEL_CTRL): ctrl_q <= data;
                SW'(SEL_MODE): pol    <= data[0];
                SW'(SEL_XTAB): xtab   <= data;
                SW'(SEL_YTAB): ytab   <= data;
                default: ;
            endcase
        end
    end

    assign ctrl = ctrl_t'(ctrl_q[7:0]);

    assert_xtab_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SW'(SEL_XTAB)) |=> (xtab == $past(data)));

    assert_foreign_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel != SW'(SEL_CTRL) && sel != SW'(SEL_MODE) &&
         sel != SW'(SEL_XTAB) && sel != SW'(SEL_YTAB))
        |=> ($stable(ctrl_q) && $stable(pol) && $stable(xtab) && $stable(ytab)));
endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
    parameter int K = 3,
    localparam int SZ = 1 << K
) (
    input  logic [SZ-1:0] tab,
    input  logic [K-1:0]  idx,
    output logic          out
);
    // table is held complemented
    assign out = ~tab[idx];
endmodule

// File: rtl/lcell_store.sv
module lcell_store (
    input  logic clk,
    input  logic rst_n,
    input  logic sr,
    input  logic pol,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (sr) q <= ~pol;
        else         q <= d;
    end

    assert_sr_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr |=> (q == !$past(pol)));

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sr |=> (q == $past(d)));
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
    import lcell_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int DW = CFG_W,
    parameter int K  = LUT_K
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_sel,
    input  logic [DW-1:0] cfg_data,
    input  logic          in_x,
    input  logic          in_y,
    input  logic          in_w,
    input  logic          in_z,
    input  logic          sr,
    output logic          out_xo,
    output logic          out_yo
);
    localparam int SZ = 1 << K;

    ctrl_t         ctrl;
    logic          pol;
    logic [DW-1:0] xtab, ytab;
    logic          wsel, zsel, fb, cen, q, dsel;
    logic [SZ-1:0] tabs [2];
    logic          tab_out [2];
    logic          xl, yl;

    lcell_cfg_bank #(.SW(SW), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
        .ctrl(ctrl), .pol(pol), .xtab(xtab), .ytab(ytab)
    );

    assign tabs[0] = xtab[SZ-1:0];
    assign tabs[1] = ytab[SZ-1:0];

    generate
        for (genvar g = 0; g < 2; g++) begin : g_lut
            lcell_lut #(.K(K)) u_lut (
                .tab(tabs[g]),
                .idx({wsel, in_y, in_x}),
                .out(tab_out[g])
            );
        end
    endgenerate

    assign xl   = tab_out[0];
    assign yl   = tab_out[1];
    assign zsel = in_z;
    assign fb   = ctrl.fb_bypass ? zsel : q;
    assign cen  = ctrl.c_bypass  ? zsel : q;

    always_comb begin
        if (ctrl.wsel_and)     wsel = in_w & in_z;
        else if (ctrl.wsel_fb) wsel = fb;
        else                   wsel = in_w;
    end

    always_comb begin
        if (ctrl.reg_from_z)       dsel = zsel;
        else if (ctrl.reg_from_yl) dsel = yl;
        else                       dsel = xl;
    end

    lcell_store u_store (
        .clk(clk), .rst_n(rst_n), .sr(sr), .pol(pol), .d(dsel), .q(q)
    );

    assign out_xo = ctrl.c_to_xo ? cen : xl;
    assign out_yo = ctrl.c_to_yo ? cen : yl;

    assert_xo_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.c_to_xo && ctrl.c_bypass) |-> (out_xo == in_z));

    assert_reg_from_z_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr && ctrl.reg_from_z) |=> (q == $past(in_z)));

    assert_centre_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.c_to_yo && !ctrl.c_bypass) |-> (out_yo == q));
endmodule

// File: tb/cfg_logic_cell_test.sv
module cfg_logic_cell_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_sel = '0;
    logic [7:0] cfg_data = '0;
    logic       x = 0, y = 0, w = 0, z = 0, sr = 0;
    logic       xo, yo;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_ctrl, m_xt, m_yt;
    logic       m_pol, mq;

    cfg_logic_cell uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .in_x(x), .in_y(y), .in_w(w), .in_z(z),
        .sr(sr), .out_xo(xo), .out_yo(yo)
    );

    always #10 clk = ~clk;

    function automatic logic e_fb();  return m_ctrl[2] ? z : mq; endfunction
    function automatic logic e_c();   return m_ctrl[3] ? z : mq; endfunction
    function automatic logic e_wm();
        return m_ctrl[5] ? (w & z) : (m_ctrl[4] ? e_fb() : w);
    endfunction
    function automatic logic e_xl();  return ~m_xt[{e_wm(), y, x}]; endfunction
    function automatic logic e_yl();  return ~m_yt[{e_wm(), y, x}]; endfunction
    function automatic logic e_xo();  return m_ctrl[1] ? e_c() : e_xl(); endfunction
    function automatic logic e_yo();  return m_ctrl[0] ? e_c() : e_yl(); endfunction
    function automatic logic e_d();
        return m_ctrl[7] ? z : (m_ctrl[6] ? e_yl() : e_xl());
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b (x%b y%b w%b z%b)",
                     req, act, exp, x, y, w, z);
        end
    endtask

    // one clock edge with the model advanced alongside
    task automatic step();
        logic nq;
        logic [7:0] nc, nx, ny;
        logic np;
        nq = sr ? ~m_pol : e_d();
        nc = m_ctrl; nx = m_xt; ny = m_yt; np = m_pol;
        if (cfg_we) begin
            case (cfg_sel)
                4'h1: nc = cfg_data;
                4'h2: np = cfg_data[0];
                4'h6: nx = cfg_data;
                4'h7: ny = cfg_data;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        mq = nq; m_ctrl = nc; m_xt = nx; m_yt = ny; m_pol = np;
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        cfg_we = 1; cfg_sel = s; cfg_data = d;
        step();
        cfg_we = 0;
    endtask

    task automatic sweep(input string req, input bit use_sr);
        for (int c = 0; c < 16; c++) begin
            x = c[0]; y = c[1]; w = c[2]; z = c[3];
            sr = use_sr ? (c[0] ^ c[2]) : 1'b0;
            @(negedge clk);
            chk(req, xo, e_xo());
            chk(req, yo, e_yo());
            step();
        end
        sr = 0;
    endtask

    initial begin
        m_ctrl = 0; m_xt = 0; m_yt = 0; m_pol = 0; mq = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R2 xo after reset", xo, 1'b1);
        chk("R2 yo after reset", yo, 1'b1);
        sweep("R2", 0);

        wr(4'h6, 8'hB4);
        wr(4'h7, 8'h1E);
        sweep("R3 default", 0);
        wr(4'h1, 8'h20); sweep("R4 and", 0);
        wr(4'h1, 8'h10); sweep("R4 fb from flop", 0);
        wr(4'h1, 8'h14); sweep("R4 fb from z", 0);
        wr(4'h1, 8'h30); sweep("R4 priority", 0);

        wr(4'h1, 8'h02); sweep("R5 xl into flop", 0);
        wr(4'h1, 8'h81); sweep("R5 z into flop", 0);
        wr(4'h1, 8'h42); sweep("R5 yl into flop", 0);
        wr(4'h1, 8'hC1); sweep("R5 priority", 0);
        wr(4'h1, 8'h52); sweep("R5 flop feedback", 0);

        wr(4'h2, 8'h00); wr(4'h1, 8'h03); sweep("R6 pol0", 1);
        wr(4'h2, 8'h01); sweep("R6 pol1", 1);
        sr = 1; step(); sr = 0;
        @(negedge clk); chk("R6 forced zero", xo, 1'b0);

        wr(4'h1, 8'h0B); sweep("R7 centre bypass", 0);
        wr(4'h1, 8'h06); sweep("R7 fb only bypass", 0);
        wr(4'h1, 8'h01); sweep("R8 yo from centre", 0);
        wr(4'h1, 8'h00); sweep("R8 defaults", 0);

        wr(4'h1, 8'h12);
        wr(4'h3, 8'hFF); wr(4'h0, 8'hFF); wr(4'h9, 8'h00); wr(4'hF, 8'hAA);
        sweep("R1 foreign selectors ignored", 0);
        wr(4'h7, 8'h99); sweep("R1 table rewrite", 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule